// File: doc/BRIEF.md
# Failover one-second pulse generator

This block produces the one-second tick that performance monitoring uses in an eight-framer device. Every framer has a receive line clock. Here each line clock is an enable strobe, sampled by a fast system clock. One of the eight strobes is the reference. A counter advances on each reference strobe. When it reaches the terminal count for the line rate, the block raises a device-level pulse for one cycle.

The terminal count depends on the line rate. A strap input, sampled while reset is held, selects between the DS1 count and the CEPT count. After reset the reference is framer 1. When the framer that supplies the reference reports loss of clock, the reference moves to the next framer that still has a clock. The search goes upward and wraps from framer 8 back to framer 1. The count carries across the switch. If every framer has lost its clock, the count freezes.

The device pulse is also handed to each framer. Each framer holds it as pending and releases it as a one-cycle pulse on that framer's next line-clock strobe. A framer whose clock is missing keeps its pulse pending. If a further second begins before that framer's clock returns, the two seconds merge and it receives only one pulse.

Top module: `spf_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `sec_pulse` and every bit of `fr_pulse` are 0.
- R2: `sec_pulse` is high for exactly one cycle. That cycle immediately follows the cycle carrying the reference strobe that completes the terminal count. Strobes are counted from reset or from the previous pulse.
- R3: The terminal count is DS1_TICKS when `mode_cept` is 0 during reset, and E1_TICKS when it is 1. Changing `mode_cept` after reset has no effect on the count.
- R4: After reset the reference is framer 1 (bit 0 of `line_tick`). Strobes on other framers do not advance the count.
- R5: If the loss flag of the current reference framer is high in a cycle, that cycle's strobe from it is not counted. From the next cycle the reference is the first framer without a loss flag, searching upward from the current one.
- R6: The search wraps from framer 8 (bit 7) to framer 1 (bit 0).
- R7: While all eight loss flags are high, the count holds and no `sec_pulse` is produced. When the flags clear, counting resumes from the held value.
- R8: A source switch keeps the count. The pulse comes after the remaining strobes of the new source, and it comes exactly once.
- R9: `fr_pulse[i]` goes high for one cycle in the cycle after the first strobe on `line_tick[i]`. Only strobes that arrive at least one cycle after the `sec_pulse` cycle count for this.
- R10: A framer with no strobes keeps its pulse pending. If another second begins first, it receives a single pulse for both seconds when its strobes return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock sampling all strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_cept | input | 1 | Line-rate strap, sampled during reset: 0 selects DS1, 1 selects CEPT |
| line_tick | input | NUM_FR | One strobe per framer, high for one cycle per line-clock period |
| clk_lost | input | NUM_FR | Loss-of-clock flag per framer |
| sec_pulse | output | 1 | Device-level one-second pulse |
| fr_pulse | output | NUM_FR | Second pulse retimed to each framer's strobe |

## Verification
`sec_pulse` is due one cycle after the strobe that completes the count. A loss flag changes the reference one cycle after it is seen, so a strobe from the new source counts from the following cycle on. `fr_pulse[i]` is due one cycle after the first strobe of framer i that follows the `sec_pulse` cycle. In the bench, each input set is applied on a falling edge and the outputs are read on the next falling edge. Every expectation is therefore written as the register state after exactly one rising edge.

// File: rtl/spf_pkg.sv
package spf_pkg;

  localparam int MAX_FR = 32;

  // Terminal tick count chosen by the strap sampled at reset.
  function automatic int unsigned term_ticks(input logic cept,
                                             input int unsigned ds1,
                                             input int unsigned e1);
    return cept ? e1 : ds1;
  endfunction

  // First framer above cur (wrapping) with no loss flag; -1 if none.
  function automatic int pick_next(input logic [MAX_FR-1:0] lost,
                                   input int cur,
                                   input int n);
    int r;
    int idx;
    r = -1;
    for (int k = n - 1; k >= 1; k--) begin
      idx = (cur + k) % n;
      if (!lost[idx]) r = idx;
    end
    return r;
  endfunction

endpackage

// File: rtl/spf_src_select.sv
module spf_src_select #(
  parameter int NUM_FR = 8,
  parameter int SW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FR-1:0] clk_lost,
  output logic [SW-1:0]     src_sel,
  output logic              src_lost
);

  logic [spf_pkg::MAX_FR-1:0] lost_w;
  int                         nxt;

  assign lost_w   = spf_pkg::MAX_FR'(clk_lost);
  assign src_lost = clk_lost[src_sel];

  always_comb begin
    nxt = spf_pkg::pick_next(lost_w, int'(src_sel), NUM_FR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel <= '0;
    end else if (src_lost && (nxt >= 0)) begin
      src_sel <= SW'(nxt);
    end
  end

endmodule

// File: rtl/spf_sec_counter.sv
module spf_sec_counter #(
  parameter int CW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic [CW-1:0] term,
  output logic [CW-1:0] cnt,
  output logic          sec_pulse
);

  logic term_hit;

  assign term_hit = ref_tick && (cnt == (term - CW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= term_hit;
      if (term_hit) begin
        cnt <= '0;
      end else if (ref_tick) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/spf_retime.sv
module spf_retime (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_pulse,
  input  logic line_tick,
  output logic fr_pulse
);

  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      fr_pulse <= 1'b0;
    end else begin
      fr_pulse <= pending && line_tick;
      pending  <= sec_pulse || (pending && !line_tick);
    end
  end

endmodule

// File: rtl/spf_top.sv
module spf_top #(
  parameter int          NUM_FR    = 8,
  parameter int unsigned DS1_TICKS = 1544000,
  parameter int unsigned E1_TICKS  = 2048000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_cept,
  input  logic [NUM_FR-1:0] line_tick,
  input  logic [NUM_FR-1:0] clk_lost,
  output logic              sec_pulse,
  output logic [NUM_FR-1:0] fr_pulse
);

  localparam int          SW   = (NUM_FR > 1) ? $clog2(NUM_FR) : 1;
  localparam int unsigned MAXT = (DS1_TICKS > E1_TICKS) ? DS1_TICKS : E1_TICKS;
  localparam int          CW   = $clog2(MAXT + 1);

  logic          mode_q;
  logic [CW-1:0] term;
  logic [SW-1:0] src_sel;
  logic          src_lost;
  logic          ref_tick;
  logic [CW-1:0] cnt;

  // Strap is captured while reset is held.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= mode_cept;
  end

  assign term     = CW'(spf_pkg::term_ticks(mode_q, DS1_TICKS, E1_TICKS));
  assign ref_tick = line_tick[src_sel] && !src_lost;

  spf_src_select #(.NUM_FR(NUM_FR), .SW(SW)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_lost (clk_lost),
    .src_sel  (src_sel),
    .src_lost (src_lost)
  );

  spf_sec_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .term      (term),
    .cnt       (cnt),
    .sec_pulse (sec_pulse)
  );

  for (genvar i = 0; i < NUM_FR; i++) begin : g_fr
    spf_retime u_rt (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_pulse (sec_pulse),
      .line_tick (line_tick[i]),
      .fr_pulse  (fr_pulse[i])
    );
  end

endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int NUM_FR = 8,
  parameter int SW     = 3,
  parameter int CW     = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_FR-1:0] line_tick,
  input logic [NUM_FR-1:0] clk_lost,
  input logic              sec_pulse,
  input logic [NUM_FR-1:0] fr_pulse,
  input logic [SW-1:0]     src_sel,
  input logic              src_lost,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     term
);

  // R2: pulse lasts one cycle
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);

  // R2: pulse only on wrap from terminal value
  a_r2_wrap_from_term: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> (cnt == '0) && ($past(cnt) == (term - CW'(1))));

  // R5: lost reference is abandoned when another framer is alive
  a_r5_leave_lost_src: assert property (@(posedge clk) disable iff (!rst_n)
    (src_lost && !(&clk_lost)) |=> (src_sel != $past(src_sel)));

  // R7: total loss freezes the count
  a_r7_hold_all_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (&clk_lost) |=> (!sec_pulse && $stable(cnt)));

  // R9: a framer pulse always follows that framer's strobe
  for (genvar i = 0; i < NUM_FR; i++) begin : g_chk
    a_r9_fr_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
      fr_pulse[i] |-> $past(line_tick[i]));
  end

endmodule

bind spf_top spf_checker #(.NUM_FR(NUM_FR), .SW(SW), .CW(CW)) u_spf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_tick (line_tick),
  .clk_lost  (clk_lost),
  .sec_pulse (sec_pulse),
  .fr_pulse  (fr_pulse),
  .src_sel   (src_sel),
  .src_lost  (src_lost),
  .cnt       (cnt),
  .term      (term)
);

// File: tb/spf_top_bench.sv
module spf_top_bench;

  localparam int NF = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_cept = 1'b0;
  logic [NF-1:0] line_tick = '0;
  logic [NF-1:0] clk_lost = '0;
  logic          sec_pulse;
  logic [NF-1:0] fr_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int sec_seen = 0;
  int fr_seen [NF];
  bit done = 0;

  always #2 clk = ~clk;

  spf_top #(.NUM_FR(NF), .DS1_TICKS(5), .E1_TICKS(7)) u_spf_top (
    .clk(clk), .rst_n(rst_n), .mode_cept(mode_cept),
    .line_tick(line_tick), .clk_lost(clk_lost),
    .sec_pulse(sec_pulse), .fr_pulse(fr_pulse)
  );

  // {tick[7:0], expected sec_pulse, expected fr_pulse[7:0]}, DS1 count 5
  localparam logic [16:0] VEC [0:9] = '{
    {8'h01, 1'b0, 8'h00}, {8'h01, 1'b0, 8'h00}, {8'h02, 1'b0, 8'h00},
    {8'h01, 1'b0, 8'h00}, {8'h01, 1'b0, 8'h00}, {8'h01, 1'b1, 8'h00},
    {8'hFF, 1'b0, 8'h00}, {8'h03, 1'b0, 8'h03}, {8'hFC, 1'b0, 8'hFC},
    {8'h00, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [NF-1:0] t, input logic [NF-1:0] l);
    line_tick = t;
    clk_lost  = l;
    @(negedge clk);
    if (sec_pulse) sec_seen++;
    for (int i = 0; i < NF; i++) if (fr_pulse[i]) fr_seen[i]++;
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0;
    mode_cept = strap;
    line_tick = '0;
    clk_lost = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sec_seen = 0;
    for (int i = 0; i < NF; i++) fr_seen[i] = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    chk("R1 sec_pulse after reset", int'(sec_pulse), 0);
    chk("R1 fr_pulse after reset", int'(fr_pulse), 0);
    step('0, '0);
    chk("R1 sec_pulse first cycle", int'(sec_pulse), 0);

    // R2 R4 R9 vector walk
    do_reset(1'b0);
    for (int v = 0; v < 10; v++) begin
      step(VEC[v][16:9], '0);
      chk($sformatf("R2 R4 vec%0d sec_pulse", v), int'(sec_pulse), int'(VEC[v][8]));
      chk($sformatf("R9 vec%0d fr_pulse", v), int'(fr_pulse), int'(VEC[v][7:0]));
    end

    // R3: CEPT strap, later strap change ignored
    do_reset(1'b1);
    mode_cept = 1'b0;
    repeat (6) step(8'h01, '0);
    chk("R3 no pulse before 7 ticks", sec_seen, 0);
    step(8'h01, '0);
    chk("R3 pulse on 7th tick", int'(sec_pulse), 1);

    // R5 R8: failover keeps count
    do_reset(1'b0);
    repeat (3) step(8'h01, '0);
    step(8'h00, 8'h01);
    repeat (2) step(8'h01, 8'h01);
    chk("R5 lost source ticks ignored", sec_seen, 0);
    step(8'h02, 8'h01);
    chk("R8 no pulse at 4", sec_seen, 0);
    step(8'h02, 8'h01);
    chk("R8 pulse after switch", int'(sec_pulse), 1);
    repeat (3) step(8'h00, 8'h01);
    chk("R8 single pulse", sec_seen, 1);

    // R6: wrap from framer 8 to framer 1
    do_reset(1'b0);
    step(8'h00, 8'h7F);
    repeat (2) step(8'h80, 8'h7F);
    step(8'h00, 8'h80);
    repeat (2) step(8'h01, 8'h80);
    step(8'h80, 8'h80);
    chk("R6 no pulse yet", sec_seen, 0);
    step(8'h01, 8'h80);
    chk("R6 pulse after wrap", int'(sec_pulse), 1);

    // R7: all lost holds count
    do_reset(1'b0);
    repeat (2) step(8'h01, '0);
    repeat (20) step(8'hFF, 8'hFF);
    chk("R7 no pulse while all lost", sec_seen, 0);
    repeat (2) step(8'h01, '0);
    chk("R7 count held", sec_seen, 0);
    step(8'h01, '0);
    chk("R7 pulse resumes", int'(sec_pulse), 1);

    // R10: framer 4 silent across two seconds
    do_reset(1'b0);
    repeat (12) step(8'hF7, 8'h08);
    chk("R10 framer1 got two", fr_seen[0], 2);
    chk("R10 silent framer pending", fr_seen[3], 0);
    step(8'h08, 8'h00);
    chk("R9 framer4 released", int'(fr_pulse[3]), 1);
    step(8'h00, 8'h00);
    chk("R10 single merged pulse", fr_seen[3], 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule